// File: doc/BRIEF.md
# Reservation Station Bank with Result Broadcast Snooping

This block holds a small pool of reservation stations for an out-of-order core that renames registers onto station tags. Each issued operation takes a free station. For each source operand, the station keeps either the operand value or the tag of the station that will produce it. A built-in rename table maps every architectural register to the tag of its latest pending producer. A reader therefore waits only on true read-after-write dependencies. Write-after-read and write-after-write conflicts disappear, because each producer writes its own station and no register name is shared between producers.

A single result bus carries one tag and one value per cycle. Every waiting station compares the tag against its own pending source tags at the same time. A station that matches takes the value and stops waiting. When the bus carries a station's own tag, that station is freed. Stations whose operands are all present are sent, oldest first and one per cycle, to a single execution unit. The unit is assumed to accept one operation every cycle. Its results later return on the result bus.

Top module: `rs_bank`

## Requirements
- R1: After a synchronous active-low reset, every station is free, `iss_full` is low and `disp_valid` is low.
- R2: Station k (counting from 0) owns tag k+1, and an accepted issue goes to the lowest-numbered free station. An operand whose register has no pending producer takes the supplied value. A station with both operands present drives `disp_valid`, `disp_op`, `disp_a`, `disp_b` and `disp_tag` in the cycle after it is issued.
- R3: An operand whose register maps to a pending tag waits on that tag, and the value supplied with the issue is ignored. The station is not dispatched while it waits.
- R4: When `cdb_valid` is high, every busy station whose pending tag equals `cdb_tag` takes `cdb_value` and stops waiting on that operand. All matching stations do this in the same cycle.
- R5: An operand whose producer broadcasts in the very cycle of the issue takes the broadcast value directly and does not wait.
- R6: An issue maps its destination register to the new station's tag. A broadcast clears a register's mapping only if the mapping still holds the broadcast tag.
- R7: At most one station is dispatched per cycle. Among ready stations the one issued earliest goes first, whatever its position. Each station is dispatched once.
- R8: A station stays busy after dispatch and is freed when its own tag is broadcast. Tag 0 means no pending producer.
- R9: `iss_full` is high exactly when no station is free. An issue presented while it is high is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code |
| iss_src_a | input | REG_W | First source register |
| iss_src_b | input | REG_W | Second source register |
| iss_dst | input | REG_W | Destination register |
| iss_val_a | input | XLEN | Register-file value of first source |
| iss_val_b | input | XLEN | Register-file value of second source |
| iss_full | output | 1 | No station free; issue not accepted |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | TAG_W | Tag of the broadcasting station |
| cdb_value | input | XLEN | Broadcast result |
| disp_valid | output | 1 | An operation is dispatched this cycle |
| disp_op | output | OP_W | Dispatched operation |
| disp_a | output | XLEN | First operand |
| disp_b | output | XLEN | Second operand |
| disp_tag | output | TAG_W | Tag the result must be broadcast with |

## Verification
Several input patterns are used. An issue with no producers pending shows that register-file values are taken as supplied. A dependent issue with a junk register value shows that the operand really waits on the tag and later takes the broadcast value. An issue in the same cycle as its producer's broadcast exercises the bypass. Two writers to one register followed by a reader separate the conditional clearing of the rename table from an unconditional one. Filling every station so that the oldest sits at a higher index than a younger one shows age order apart from index order, and it also exercises the full condition and the rejection of an issue while full.

// File: rtl/rs_pkg.sv
// Shared defaults and helpers for the reservation station bank.
// Assumes tag 0 is reserved for "no pending producer".
package rs_pkg;
    localparam int DEF_NUM_RS   = 4;
    localparam int DEF_XLEN     = 16;
    localparam int DEF_NUM_REGS = 8;
    localparam int DEF_OP_W     = 4;

    // Width needed to name n stations plus the reserved ready tag.
    function automatic int tag_width(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/rs_rename_table.sv
// Register-to-tag map. Reads are combinational. One issue write and one
// broadcast clear per cycle; the write wins when both hit the same register.
// Assumes a clear applies only to entries still holding the broadcast tag.
module rs_rename_table #(
    parameter int NUM_REGS = 8,
    parameter int TAG_W    = 3,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] rd_a_idx,
    input  logic [REG_W-1:0] rd_b_idx,
    output logic [TAG_W-1:0] rd_a_tag,
    output logic [TAG_W-1:0] rd_b_tag,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             clr_en,
    input  logic [TAG_W-1:0] clr_tag
);
    logic [TAG_W-1:0] map_q [NUM_REGS];

    // Look up the producers of both sources.
    always_comb begin
        rd_a_tag = map_q[rd_a_idx];
        rd_b_tag = map_q[rd_b_idx];
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        // Rename on issue; retire the mapping when its producer broadcasts.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                map_q[r] <= '0;
            end else if (wr_en && wr_idx == REG_W'(r)) begin
                map_q[r] <= wr_tag;
            end else if (clr_en && clr_tag != '0 && map_q[r] == clr_tag) begin
                map_q[r] <= '0;
            end
        end
    end
endmodule

// File: rtl/rs_station.sv
// One reservation station. Holds op, two operand values and two producer
// tags. Snoops the result bus, raises ready once both tags are clear, and
// frees itself when its own tag is broadcast.
// Assumes an allocation only targets a free station.
module rs_station #(
    parameter int XLEN   = 16,
    parameter int OP_W   = 4,
    parameter int TAG_W  = 3,
    parameter int MY_TAG = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic [OP_W-1:0]  alloc_op,
    input  logic [XLEN-1:0]  alloc_vj,
    input  logic [TAG_W-1:0] alloc_qj,
    input  logic [XLEN-1:0]  alloc_vk,
    input  logic [TAG_W-1:0] alloc_qk,
    input  logic             cdb_valid,
    input  logic [TAG_W-1:0] cdb_tag,
    input  logic [XLEN-1:0]  cdb_value,
    input  logic             grant,
    output logic             busy,
    output logic             ready,
    output logic [OP_W-1:0]  op,
    output logic [XLEN-1:0]  vj,
    output logic [XLEN-1:0]  vk,
    output logic [TAG_W-1:0] qj,
    output logic [TAG_W-1:0] qk
);
    logic sent;
    logic hit_j, hit_k, hit_own;

    // Decode the broadcast against this station's fields.
    always_comb begin
        hit_j   = cdb_valid && qj != '0 && qj == cdb_tag;
        hit_k   = cdb_valid && qk != '0 && qk == cdb_tag;
        hit_own = cdb_valid && cdb_tag == TAG_W'(MY_TAG);
        ready   = busy && !sent && qj == '0 && qk == '0;
    end

    // Load on allocation, capture broadcasts, mark dispatch, free on own tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            sent <= 1'b0;
            op   <= '0;
            vj   <= '0;
            vk   <= '0;
            qj   <= '0;
            qk   <= '0;
        end else if (alloc) begin
            busy <= 1'b1;
            sent <= 1'b0;
            op   <= alloc_op;
            vj   <= alloc_vj;
            vk   <= alloc_vk;
            qj   <= alloc_qj;
            qk   <= alloc_qk;
        end else if (busy) begin
            if (hit_own) begin
                busy <= 1'b0;
            end
            if (hit_j) begin
                vj <= cdb_value;
                qj <= '0;
            end
            if (hit_k) begin
                vk <= cdb_value;
                qk <= '0;
            end
            if (grant) begin
                sent <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rs_age_pick.sv
// Age matrix and oldest-ready picker. older_q[i][j] set means station i
// was allocated before station j. A new allocation becomes younger than all.
// Assumes at most one allocation per cycle.
module rs_age_pick #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] alloc_vec,
    input  logic [N-1:0] ready_vec,
    output logic [N-1:0] grant_vec
);
    logic [N-1:0] older_q [N];

    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            if (i == j) begin : g_diag
                // Diagonal is never consulted; hold it at zero.
                always_ff @(posedge clk) older_q[i][j] <= 1'b0;
            end else begin : g_off
                // Track pairwise allocation order.
                always_ff @(posedge clk) begin
                    if (!rst_n)            older_q[i][j] <= (i < j);
                    else if (alloc_vec[j]) older_q[i][j] <= 1'b1;
                    else if (alloc_vec[i]) older_q[i][j] <= 1'b0;
                end
            end
        end

        // Grant station i when it is ready and older than every other ready one.
        always_comb begin
            grant_vec[i] = ready_vec[i];
            for (int j = 0; j < N; j++) begin
                if (j != i && ready_vec[j] && !older_q[i][j]) grant_vec[i] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/rs_bank.sv
// Reservation station bank: allocation of the lowest free station,
// operand resolution through the rename table with same-cycle broadcast
// bypass, result-bus snooping and oldest-first dispatch to one unit.
// Assumes the execution unit accepts a dispatch every cycle and that
// only tags of busy, dispatched stations are broadcast.
module rs_bank #(
    parameter int NUM_RS   = rs_pkg::DEF_NUM_RS,
    parameter int XLEN     = rs_pkg::DEF_XLEN,
    parameter int NUM_REGS = rs_pkg::DEF_NUM_REGS,
    parameter int OP_W     = rs_pkg::DEF_OP_W,
    localparam int TAG_W   = rs_pkg::tag_width(NUM_RS),
    localparam int REG_W   = $clog2(NUM_REGS),
    localparam int IDX_W   = $clog2(NUM_RS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic [OP_W-1:0]  iss_op,
    input  logic [REG_W-1:0] iss_src_a,
    input  logic [REG_W-1:0] iss_src_b,
    input  logic [REG_W-1:0] iss_dst,
    input  logic [XLEN-1:0]  iss_val_a,
    input  logic [XLEN-1:0]  iss_val_b,
    output logic             iss_full,
    input  logic             cdb_valid,
    input  logic [TAG_W-1:0] cdb_tag,
    input  logic [XLEN-1:0]  cdb_value,
    output logic             disp_valid,
    output logic [OP_W-1:0]  disp_op,
    output logic [XLEN-1:0]  disp_a,
    output logic [XLEN-1:0]  disp_b,
    output logic [TAG_W-1:0] disp_tag
);
    logic [NUM_RS-1:0]             busy_vec, ready_vec, grant_vec, alloc_vec;
    logic [NUM_RS-1:0][OP_W-1:0]   op_arr;
    logic [NUM_RS-1:0][XLEN-1:0]   vj_arr, vk_arr;
    logic [NUM_RS-1:0][TAG_W-1:0]  qj_arr, qk_arr;
    logic [IDX_W-1:0]              free_idx;
    logic                          any_free, accept;
    logic [TAG_W-1:0]              new_tag, map_a, map_b, res_qj, res_qk;
    logic [XLEN-1:0]               res_vj, res_vk;

    // Find the lowest free station.
    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = NUM_RS - 1; i >= 0; i--) begin
            if (!busy_vec[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
        iss_full  = !any_free;
        accept    = iss_valid && any_free;
        new_tag   = TAG_W'(free_idx) + TAG_W'(1);
        alloc_vec = '0;
        if (accept) alloc_vec[free_idx] = 1'b1;
    end

    rs_rename_table #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (iss_src_a),
        .rd_b_idx (iss_src_b),
        .rd_a_tag (map_a),
        .rd_b_tag (map_b),
        .wr_en    (accept),
        .wr_idx   (iss_dst),
        .wr_tag   (new_tag),
        .clr_en   (cdb_valid),
        .clr_tag  (cdb_tag)
    );

    // Resolve each source to a value or a pending tag, bypassing the bus.
    always_comb begin
        res_vj = iss_val_a;
        res_qj = map_a;
        if (map_a == '0) begin
            res_qj = '0;
        end else if (cdb_valid && cdb_tag == map_a) begin
            res_vj = cdb_value;
            res_qj = '0;
        end
        res_vk = iss_val_b;
        res_qk = map_b;
        if (map_b == '0) begin
            res_qk = '0;
        end else if (cdb_valid && cdb_tag == map_b) begin
            res_vk = cdb_value;
            res_qk = '0;
        end
    end

    for (genvar g = 0; g < NUM_RS; g++) begin : g_rs
        rs_station #(.XLEN(XLEN), .OP_W(OP_W), .TAG_W(TAG_W), .MY_TAG(g + 1)) u_rs (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc     (alloc_vec[g]),
            .alloc_op  (iss_op),
            .alloc_vj  (res_vj),
            .alloc_qj  (res_qj),
            .alloc_vk  (res_vk),
            .alloc_qk  (res_qk),
            .cdb_valid (cdb_valid),
            .cdb_tag   (cdb_tag),
            .cdb_value (cdb_value),
            .grant     (grant_vec[g]),
            .busy      (busy_vec[g]),
            .ready     (ready_vec[g]),
            .op        (op_arr[g]),
            .vj        (vj_arr[g]),
            .vk        (vk_arr[g]),
            .qj        (qj_arr[g]),
            .qk        (qk_arr[g])
        );
    end

    rs_age_pick #(.N(NUM_RS)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_vec (alloc_vec),
        .ready_vec (ready_vec),
        .grant_vec (grant_vec)
    );

    // Steer the granted station onto the dispatch port.
    always_comb begin
        disp_valid = |grant_vec;
        disp_op    = '0;
        disp_a     = '0;
        disp_b     = '0;
        disp_tag   = '0;
        for (int i = 0; i < NUM_RS; i++) begin
            if (grant_vec[i]) begin
                disp_op  = disp_op  | op_arr[i];
                disp_a   = disp_a   | vj_arr[i];
                disp_b   = disp_b   | vk_arr[i];
                disp_tag = disp_tag | TAG_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/rs_bank_chk.sv
// Assertion checker for rs_bank, bound to every instance.
module rs_bank_chk #(
    parameter int NUM_RS = 4,
    parameter int XLEN   = 16,
    parameter int TAG_W  = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cdb_valid,
    input logic [TAG_W-1:0]              cdb_tag,
    input logic [XLEN-1:0]               cdb_value,
    input logic                          disp_valid,
    input logic [TAG_W-1:0]              disp_tag,
    input logic                          iss_full,
    input logic [NUM_RS-1:0]             busy_vec,
    input logic [NUM_RS-1:0]             grant_vec,
    input logic [NUM_RS-1:0][TAG_W-1:0]  qj_arr,
    input logic [NUM_RS-1:0][XLEN-1:0]   vj_arr
);
    // R7
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));

    // R7
    no_redispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> !(disp_valid && disp_tag == $past(disp_tag)));

    // R8
    tag_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> disp_tag != '0);

    // R9
    full_all_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_full |-> &busy_vec);

    for (genvar i = 0; i < NUM_RS; i++) begin : g_st
        // R4
        capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cdb_valid && busy_vec[i] && qj_arr[i] != '0 && qj_arr[i] == cdb_tag)
            |=> (qj_arr[i] == '0 && vj_arr[i] == $past(cdb_value)));

        // R8
        free_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cdb_valid && busy_vec[i] && cdb_tag == TAG_W'(i + 1)) |=> !busy_vec[i]);
    end
endmodule

bind rs_bank rs_bank_chk #(.NUM_RS(NUM_RS), .XLEN(XLEN), .TAG_W(TAG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cdb_valid  (cdb_valid),
    .cdb_tag    (cdb_tag),
    .cdb_value  (cdb_value),
    .disp_valid (disp_valid),
    .disp_tag   (disp_tag),
    .iss_full   (iss_full),
    .busy_vec   (busy_vec),
    .grant_vec  (grant_vec),
    .qj_arr     (qj_arr),
    .vj_arr     (vj_arr)
);

// File: tb/tb_rs_bank.sv
`timescale 1ns/1ps
module tb_rs_bank;
    localparam int NUM_RS = 4, XLEN = 16, NUM_REGS = 8, OP_W = 4;
    localparam int TAG_W = $clog2(NUM_RS + 1);
    localparam int REG_W = $clog2(NUM_REGS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iss_valid = 1'b0;
    logic [OP_W-1:0]  iss_op = '0;
    logic [REG_W-1:0] iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
    logic [XLEN-1:0]  iss_val_a = '0, iss_val_b = '0;
    logic iss_full;
    logic cdb_valid = 1'b0;
    logic [TAG_W-1:0] cdb_tag = '0;
    logic [XLEN-1:0]  cdb_value = '0;
    logic disp_valid;
    logic [OP_W-1:0]  disp_op;
    logic [XLEN-1:0]  disp_a, disp_b;
    logic [TAG_W-1:0] disp_tag;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    rs_bank #(.NUM_RS(NUM_RS), .XLEN(XLEN), .NUM_REGS(NUM_REGS), .OP_W(OP_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_src_a(iss_src_a),
        .iss_src_b(iss_src_b), .iss_dst(iss_dst), .iss_val_a(iss_val_a),
        .iss_val_b(iss_val_b), .iss_full(iss_full),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .disp_valid(disp_valid), .disp_op(disp_op), .disp_a(disp_a),
        .disp_b(disp_b), .disp_tag(disp_tag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        iss_valid = 1'b0;
        cdb_valid = 1'b0;
    endtask

    task automatic issue(input int op, input int a, input int b, input int d,
                         input int va, input int vb);
        iss_valid = 1'b1;
        iss_op    = OP_W'(op);
        iss_src_a = REG_W'(a);
        iss_src_b = REG_W'(b);
        iss_dst   = REG_W'(d);
        iss_val_a = XLEN'(va);
        iss_val_b = XLEN'(vb);
    endtask

    task automatic bcast(input int tag, input int val);
        cdb_valid = 1'b1;
        cdb_tag   = TAG_W'(tag);
        cdb_value = XLEN'(val);
    endtask

    task automatic expect_disp(input string req, input int tag, input int a, input int b);
        #1;
        check(disp_valid == 1'b1, req, int'(disp_valid), 1);
        check(disp_tag == TAG_W'(tag), req, int'(disp_tag), tag);
        check(disp_a == XLEN'(a), req, int'(disp_a), a);
        check(disp_b == XLEN'(b), req, int'(disp_b), b);
    endtask

    task automatic expect_none(input string req);
        #1;
        check(disp_valid == 1'b0, req, int'(disp_valid), 0);
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        #1;
        check(iss_full == 1'b0, "R1 full", int'(iss_full), 0);
        check(disp_valid == 1'b0, "R1 disp", int'(disp_valid), 0);
    endtask

    // R2: operands ready at issue; R8 freeing
    task automatic t_ready_issue();
        step(); issue(3, 2, 3, 1, 10, 20);
        step(); idle();
        expect_disp("R2 ready issue", 1, 10, 20);
        check(disp_op == 4'd3, "R2 op", int'(disp_op), 3);
        step(); expect_none("R7 once"); bcast(1, 30);
        step(); idle();
    endtask

    // R3/R4: dependent operand waits, then takes broadcast
    task automatic t_raw_wait();
        step(); issue(5, 2, 3, 1, 4, 6);
        step(); expect_disp("R8 freed tag reused", 1, 4, 6); issue(6, 1, 5, 4, 999, 8);
        step(); idle(); expect_none("R3 waits"); bcast(1, 77);
        step(); idle(); expect_disp("R4 capture", 2, 77, 8);
        step(); bcast(2, 0);
        step(); idle();
    endtask

    // R5: same-cycle bypass
    task automatic t_bypass();
        step(); issue(1, 0, 0, 3, 1, 2);
        step(); expect_disp("R2", 1, 1, 2); issue(2, 3, 3, 5, 0, 0); bcast(1, 55);
        step(); idle(); expect_disp("R5 bypass", 2, 55, 55);
        step(); bcast(2, 0);
        step(); idle();
    endtask

    // R6: stale broadcast must not clear a newer mapping
    task automatic t_waw_rename();
        step(); issue(1, 0, 0, 6, 1, 1);
        step(); issue(1, 0, 0, 6, 2, 2);
        step(); idle(); bcast(1, 11);
        step(); idle(); issue(7, 6, 0, 2, 0, 3);
        step(); idle(); expect_none("R6 waits newest"); bcast(2, 22);
        step(); idle(); expect_disp("R6 newest value", 1, 22, 3);
        step(); bcast(1, 0);
        step(); idle();
    endtask

    // R7/R9/R4: oldest first at a higher index, full, rejected issue
    task automatic t_oldest_full();
        step(); issue(1, 0, 0, 1, 0, 0);
        step(); issue(1, 0, 0, 2, 0, 0);
        step(); issue(2, 2, 0, 5, 0, 9);
        step(); idle(); bcast(1, 0);
        step(); idle(); issue(3, 2, 0, 6, 0, 10);
        step(); issue(4, 2, 0, 7, 0, 11);
        step(); idle(); #1;
        check(iss_full == 1'b1, "R9 full", int'(iss_full), 1);
        issue(9, 0, 0, 3, 1, 1); bcast(2, 42);
        step(); idle(); #1;
        check(iss_full == 1'b0, "R9 not full", int'(iss_full), 0);
        expect_disp("R7 oldest", 3, 42, 9);
        step(); expect_disp("R7 next", 1, 42, 10);
        step(); expect_disp("R7 youngest", 4, 42, 11);
        step(); expect_none("R9 rejected issue");
        bcast(3, 0); step(); bcast(1, 0); step(); bcast(4, 0);
        step(); idle(); #1;
        check(iss_full == 1'b0, "R8 all freed", int'(iss_full), 0);
    endtask

    initial begin
        t_reset();
        t_ready_issue();
        t_raw_wait();
        t_bypass();
        t_waw_rename();
        t_oldest_full();
        step();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end
endmodule